// File: doc/BRIEF.md
# Byte-wise Inversion and Reversal Encoder

This block prepares a data word for a link that sends each field as a count of pulses, so that smaller field values mean shorter transmissions. The word is cut into byte-wide segments. Each segment is first complemented if ones form a majority of its bits. It is then mirrored end to end if the mirrored value is numerically smaller. A two-bit code per segment records which of the two transforms were applied, so that a receiver can undo them.

The encoded segments, the per-segment codes and a combined code are captured in an output register one cycle after a word is accepted. The combined code places the lowest segment's code in the most significant position. The encoded word is laid out so that each of its nibbles is one sub-segment, ready for a downstream pulse generator. The input uses a valid/ready handshake. The output holds its value with a valid strobe until a downstream ready consumes it.

Top module: `seg_invrev_encoder`

## Requirements
- R1: Segment 0 is `in_data[7:0]` and segment 1 is `in_data[15:8]`. The encoded form of segment k appears on `out_enc[8k+7:8k]`.
- R2: A segment is complemented when it contains 5 or more ones. Complementing sets bit 1 of that segment's code.
- R3: After the complement decision, the byte is mirrored (bit i moves to bit 7-i) only when the mirrored value is strictly smaller. A byte whose mirror is equal to it is left unmirrored. Mirroring sets bit 0 of the segment's code.
- R4: The code for segment k appears on `out_flags[2k+1:2k]`. The values are 0 for untouched, 1 for mirrored only, 2 for complemented only and 3 for both. Applying the code's inverse steps to the encoded byte gives back the input byte.
- R5: `out_cflags` equals {code of segment 0, code of segment 1}, with segment 0's code in bits [3:2]. For input 0xFE1F the value is 14.
- R6: The sub-segments are the nibbles of `out_enc`. SS0 is bits [3:0], SS1 is bits [7:4], SS2 is bits [11:8] and SS3 is bits [15:12]. For input 0xFE1F they are 7, 0, 1 and 0.
- R7: A word accepted at a clock edge (in_valid and in_ready both high) is shown on the outputs with out_valid high after that edge. out_valid falls after an edge where the output is consumed and no new word is accepted.
- R8: While out_valid is high and out_ready is low, in_ready is low and all output data holds steady.
- R9: While reset is asserted, out_valid is low and in_ready is high. Asserting reset drops a pending output.
- R10: A segment with exactly 4 ones is not complemented.
- R11: Every encoded segment contains at most 4 ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Block can take a word this cycle |
| in_data | input | 16 | Raw data word |
| out_valid | output | 1 | Output register holds an unconsumed result |
| out_ready | input | 1 | Downstream takes the result |
| out_enc | output | 16 | Encoded segments; nibbles are sub-segments SS0..SS3 |
| out_flags | output | 4 | Per-segment two-bit codes, segment k at [2k+1:2k] |
| out_cflags | output | 4 | Combined code, segment 0 code in the upper pair |

## Verification
The bench builds the block with its default sizes: two 8-bit segments in a 16-bit word. At that size every byte value can be driven through both segment positions in a 256-word sweep, so the majority threshold, the equal-mirror case and every code value are reached exhaustively. A hand-computed table pins down the worked values. Directed sequences then cover back-pressure, pass-through on a simultaneous drain and accept, and reset while a result is pending.

// File: rtl/seg_enc_pkg.sv
package seg_enc_pkg;

  localparam int CODE_W  = 2;
  localparam int INV_POS = 1;
  localparam int REV_POS = 0;

  typedef enum logic [CODE_W-1:0] {
    CODE_PLAIN  = 2'd0,
    CODE_MIRROR = 2'd1,
    CODE_COMPL  = 2'd2,
    CODE_BOTH   = 2'd3
  } seg_code_e;

endpackage

// File: rtl/seg_code_unit.sv
module seg_code_unit
  import seg_enc_pkg::*;
#(
  parameter int SEG_W = 8
) (
  input  logic [SEG_W-1:0]  seg_in,
  output logic [SEG_W-1:0]  seg_out,
  output logic [CODE_W-1:0] seg_code
);

  localparam int CNT_W = $clog2(SEG_W + 1);
  localparam int HALF  = SEG_W / 2;

  function automatic logic [CNT_W-1:0] ones_count(input logic [SEG_W-1:0] x);
    logic [CNT_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < SEG_W; i++) acc = acc + CNT_W'(x[i]);
    return acc;
  endfunction

  function automatic logic [SEG_W-1:0] mirror(input logic [SEG_W-1:0] x);
    logic [SEG_W-1:0] m;
    for (int i = 0; i < SEG_W; i++) m[i] = x[SEG_W-1-i];
    return m;
  endfunction

  function automatic logic [SEG_W-1:0] undo(input logic [SEG_W-1:0] x,
                                             input logic [CODE_W-1:0] c);
    logic [SEG_W-1:0] v;
    v = c[REV_POS] ? mirror(x) : x;
    v = c[INV_POS] ? ~v : v;
    return v;
  endfunction

  logic [CNT_W-1:0] ones_in;
  logic             inv_taken;
  logic [SEG_W-1:0] stage_val;
  logic [SEG_W-1:0] mirror_val;
  logic             rev_taken;

  always_comb begin
    ones_in    = ones_count(seg_in);
    inv_taken  = ones_in > CNT_W'(HALF);
    stage_val  = inv_taken ? ~seg_in : seg_in;
    mirror_val = mirror(stage_val);
    rev_taken  = mirror_val < stage_val;
    seg_out    = rev_taken ? mirror_val : stage_val;
    seg_code   = {inv_taken, rev_taken};
  end

  always_comb begin
    // R11
    seg_ones_bound_chk: assert (ones_count(seg_out) <= CNT_W'(HALF))
      else $error("encoded segment has too many ones");
    // R4
    seg_roundtrip_chk: assert (undo(seg_out, seg_code) == seg_in)
      else $error("code does not restore the input segment");
  end

endmodule

// File: rtl/seg_enc_outreg.sv
module seg_enc_outreg #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  logic accept_ev;
  logic drain_ev;

  assign in_ready  = !out_valid || out_ready;
  assign accept_ev = in_valid && in_ready;
  assign drain_ev  = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (accept_ev) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
    end else if (drain_ev) begin
      out_valid <= 1'b0;
    end
  end

  // R7
  load_then_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ev |=> out_valid);
  // R7
  idle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_ev && !accept_ev) |=> !out_valid);
  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: rtl/seg_invrev_encoder.sv
module seg_invrev_encoder
  import seg_enc_pkg::*;
#(
  parameter int SEG_W   = 8,
  parameter int NUM_SEG = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [SEG_W*NUM_SEG-1:0]  in_data,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [SEG_W*NUM_SEG-1:0]  out_enc,
  output logic [CODE_W*NUM_SEG-1:0] out_flags,
  output logic [CODE_W*NUM_SEG-1:0] out_cflags
);

  localparam int DATA_W = SEG_W * NUM_SEG;
  localparam int FLAG_W = CODE_W * NUM_SEG;
  localparam int PAY_W  = DATA_W + 2 * FLAG_W;

  logic [DATA_W-1:0] enc_word;
  logic [FLAG_W-1:0] code_word;
  logic [FLAG_W-1:0] comb_word;
  logic [PAY_W-1:0]  pay_in;
  logic [PAY_W-1:0]  pay_out;

  for (genvar k = 0; k < NUM_SEG; k++) begin : g_seg
    logic [CODE_W-1:0] code_k;
    seg_code_unit #(.SEG_W(SEG_W)) code_i (
      .seg_in   (in_data[k*SEG_W +: SEG_W]),
      .seg_out  (enc_word[k*SEG_W +: SEG_W]),
      .seg_code (code_k)
    );
    assign code_word[k*CODE_W +: CODE_W]                   = code_k;
    assign comb_word[FLAG_W-CODE_W-k*CODE_W +: CODE_W]     = code_k;
  end

  assign pay_in = {comb_word, code_word, enc_word};

  seg_enc_outreg #(.W(PAY_W)) oreg_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (pay_in),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (pay_out)
  );

  assign out_enc    = pay_out[DATA_W-1:0];
  assign out_flags  = pay_out[DATA_W +: FLAG_W];
  assign out_cflags = pay_out[DATA_W+FLAG_W +: FLAG_W];

  // R9
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && in_ready));

endmodule

// File: tb/seg_invrev_encoder_tb_top.sv
`timescale 1ns/1ps
module seg_invrev_encoder_tb_top;

  localparam int DATA_W = 16;
  localparam int FW     = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              in_valid;
  logic              in_ready;
  logic [DATA_W-1:0] in_data;
  logic              out_valid;
  logic              out_ready;
  logic [DATA_W-1:0] out_enc;
  logic [FW-1:0]     out_flags;
  logic [FW-1:0]     out_cflags;

  always #5 clk = ~clk;

  seg_invrev_encoder dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_enc(out_enc), .out_flags(out_flags), .out_cflags(out_cflags)
  );

  int  n_run  = 0;
  int  n_fail = 0;
  bit  finished = 0;

  // {data, encoded word, per-segment codes, combined code}
  localparam logic [39:0] VEC [0:8] = '{
    40'hFE1F_0107_B_E,
    40'h0000_0000_0_0,
    40'hFFFF_0000_A_A,
    40'h8001_0101_4_1,
    40'h0F0F_0F0F_0_0,
    40'hF0F0_0F0F_5_5,
    40'h1881_1881_0_0,
    40'hF8E7_0718_A_A,
    40'h3E01_8301_C_3
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // returns {code, value} for one byte, from the requirement wording
  function automatic logic [9:0] model_seg(input logic [7:0] b);
    int       cnt;
    logic     inv, rev;
    logic [7:0] v, r;
    cnt = 0;
    for (int i = 0; i < 8; i++) if (b[i]) cnt++;
    inv = (cnt >= 5);
    v   = inv ? ~b : b;
    for (int i = 0; i < 8; i++) r[7-i] = v[i];
    rev = (r < v);
    return {inv, rev, (rev ? r : v)};
  endfunction

  task automatic send(input logic [DATA_W-1:0] d);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [9:0] m0, m1;
    logic [DATA_W-1:0] d;
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 reset out_valid", 32'(out_valid), 32'd0);
    chk("R9 reset in_ready", 32'(in_ready), 32'd1);
    rst_n = 1'b1;

    // table walk
    for (int i = 0; i < 9; i++) begin
      send(VEC[i][39:24]);
      chk("R7 valid after accept", 32'(out_valid), 32'd1);
      chk("R1 R2 R3 R10 encoded word", 32'(out_enc), 32'(VEC[i][23:8]));
      chk("R4 segment codes", 32'(out_flags), 32'(VEC[i][7:4]));
      chk("R5 combined code", 32'(out_cflags), 32'(VEC[i][3:0]));
    end

    // R6 sub-segments of the worked word
    send(16'hFE1F);
    chk("R6 SS0", 32'(out_enc[3:0]), 32'd7);
    chk("R6 SS1", 32'(out_enc[7:4]), 32'd0);
    chk("R6 SS2", 32'(out_enc[11:8]), 32'd1);
    chk("R6 SS3", 32'(out_enc[15:12]), 32'd0);
    chk("R5 worked combined", 32'(out_cflags), 32'd14);

    // exhaustive byte sweep through both positions
    for (int v = 0; v < 256; v++) begin
      d  = {8'(v * 37 + 11), 8'(v)};
      m0 = model_seg(d[7:0]);
      m1 = model_seg(d[15:8]);
      send(d);
      chk("R2 R3 R11 sweep word", {out_enc, out_flags, out_cflags, 8'h00},
          {m1[7:0], m0[7:0], m1[9:8], m0[9:8], m0[9:8], m1[9:8], 8'h00});
    end

    // R7 output drops when drained with nothing new
    @(negedge clk);
    chk("R7 valid drops after drain", 32'(out_valid), 32'd0);

    // R8 back-pressure
    out_ready = 1'b0;
    send(16'h3E01);
    chk("R8 in_ready low while held", 32'(in_ready), 32'd0);
    in_valid = 1'b1;
    in_data  = 16'hFFFF;
    repeat (2) @(negedge clk);
    chk("R8 held data stable", 32'(out_enc), 32'h8301);
    chk("R8 held codes stable", 32'(out_flags), 32'hC);
    chk("R8 still valid", 32'(out_valid), 32'd1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R7 pass-through replaces output", 32'(out_enc), 32'h0000);
    chk("R7 pass-through codes", 32'(out_flags), 32'hA);
    chk("R7 pass-through valid", 32'(out_valid), 32'd1);

    // R9 reset drops a pending result
    out_ready = 1'b0;
    send(16'h8001);
    chk("R9 pending before reset", 32'(out_valid), 32'd1);
    rst_n = 1'b0;
    #1;
    chk("R9 reset drops pending", 32'(out_valid), 32'd0);
    chk("R9 reset frees input", 32'(in_ready), 32'd1);
    @(negedge clk);
    rst_n = 1'b1;
    out_ready = 1'b1;
    @(negedge clk);
    chk("R9 idle after reset", 32'(out_valid), 32'd0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule